// File: doc/BRIEF.md
# Reset Start-Address NOP Injector

After reset, this block makes a processor begin real execution at an address picked by a 4-bit switch setting. While it is injecting, the processor's data input sees a constant no-operation opcode (all zeros), whatever memory returns. The processor therefore executes NOPs and its address counts upward. Once the top nibble of the address equals the switch value, the block hands the data input over to memory read data and raises a bus-enable output for the external data-bus path.

The nibble equality is a raw combinational decode. It can briefly show a false match while address bits are settling, so it is never used as a clock and never sets the hand-off state directly. The block first gates the equality with an address-valid strobe, which is only high while the address is stable. The gated result then passes through a synchronizing register on the system clock, and only the output of that register sets a sticky hand-off flag. Under the default parameters the hand-off takes effect two clock edges after the first valid matching address is sampled. The flag stays set until the next reset.

Top module: `boot_vector_injector`

## Requirements
- R1: While reset (active high, synchronous) is sampled high, the next cycle shows bus_en = 0 and cpu_din = 8'h00.
- R2: While hand-off has not occurred, cpu_din equals 8'h00 (the NOP opcode) for any mem_rdata value, and bus_en is 0.
- R3: An address nibble equal to the switch value has no effect while addr_valid is 0. The pipeline stays empty and bus_en stays 0.
- R4: If addr_valid = 1 and cpu_addr_hi == jump_sel are sampled at clock edge k, bus_en is still 0 after edge k and is 1 after edge k+1. This is a two-edge latency with one synchronizing stage.
- R5: Once bus_en is 1, cpu_din equals mem_rdata combinationally, in the same cycle.
- R6: Once set, bus_en stays 1 until reset, however later addresses, strobes or switch values change.
- R7: A valid match that lasts a single clock cycle is enough to cause the hand-off.
- R8: Reset clears a match that is still in the synchronizing stage, so no hand-off follows from it.
- R9: Any of the 16 switch values selects its own start nibble. Only the exact 4-bit equality triggers the hand-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr_hi | input | 4 | Upper address nibble from the processor |
| addr_valid | input | 1 | High while the address is stable and may be compared |
| jump_sel | input | 4 | Start nibble from configuration switches |
| mem_rdata | input | 8 | Read data from memory |
| cpu_din | output | 8 | Data presented to the processor: NOP or memory data |
| bus_en | output | 1 | High once the hand-off has occurred; enables the data-bus path |

## Verification
The hardest case to reach is a transient equality. The address nibble briefly equals the switch value while the strobe is low, and a correct design must ignore it. The stimulus sweeps the address upward and, between every pair of strobed addresses, inserts an unstrobed cycle that carries exactly the target nibble. Any hand-off triggered by the raw decode would then appear at the wrong cycle. A second hard case is a match still held in the synchronizing stage when reset arrives. The bench sets this up with a one-cycle valid match that is followed immediately by reset.

// File: rtl/bvi_pkg.sv
package bvi_pkg;
  localparam int NIB_W_DEF  = 4;
  localparam int DATA_W_DEF = 8;
  localparam int SYNC_DEF   = 1;

  // Equality of the upper address nibble with the switch setting.
  function automatic logic nibble_hit(input logic [NIB_W_DEF-1:0] addr,
                                      input logic [NIB_W_DEF-1:0] sel);
    return addr == sel;
  endfunction
endpackage

// File: rtl/bvi_match_qual.sv
module bvi_match_qual #(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0] addr_hi,
  input  logic [NIB_W-1:0] sel,
  input  logic             addr_valid,
  output logic             raw_eq,
  output logic             qual_hit
);
  // The raw decode may glitch; it only ever feeds the strobe gate.
  assign raw_eq   = (addr_hi == sel);
  assign qual_hit = addr_valid & raw_eq;
endmodule

// File: rtl/bvi_sync_chain.sv
module bvi_sync_chain #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[0] <= 1'b0;
        else     pipe[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= 1'b0;
        else     pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/bvi_handoff_latch.sv
module bvi_handoff_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_in,
  output logic held
);
  always_ff @(posedge clk) begin
    if (rst)         held <= 1'b0;
    else if (set_in) held <= 1'b1;
  end
endmodule

// File: rtl/bvi_data_mux.sv
module bvi_data_mux #(
  parameter int          DATA_W = 8,
  parameter logic [7:0]  NOP    = 8'h00
) (
  input  logic              use_mem,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] cpu_din
);
  localparam logic [DATA_W-1:0] NOP_W = DATA_W'(NOP);
  always_comb begin
    if (use_mem) cpu_din = mem_rdata;
    else         cpu_din = NOP_W;
  end
endmodule

// File: rtl/boot_vector_injector.sv
module boot_vector_injector
  import bvi_pkg::*;
#(
  parameter int         NIB_W       = NIB_W_DEF,
  parameter int         DATA_W      = DATA_W_DEF,
  parameter int         SYNC_STAGES = SYNC_DEF,
  parameter logic [7:0] NOP_CODE    = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NIB_W-1:0]  cpu_addr_hi,
  input  logic              addr_valid,
  input  logic [NIB_W-1:0]  jump_sel,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] cpu_din,
  output logic              bus_en
);
  // Named internal events, observed by the bound checker.
  logic raw_eq;
  logic qual_hit;
  logic sync_hit;
  logic handoff;

  bvi_match_qual #(.NIB_W(NIB_W)) u_qual (
    .addr_hi    (cpu_addr_hi),
    .sel        (jump_sel),
    .addr_valid (addr_valid),
    .raw_eq     (raw_eq),
    .qual_hit   (qual_hit)
  );

  bvi_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (qual_hit),
    .q   (sync_hit)
  );

  bvi_handoff_latch u_latch (
    .clk    (clk),
    .rst    (rst),
    .set_in (sync_hit),
    .held   (handoff)
  );

  bvi_data_mux #(.DATA_W(DATA_W), .NOP(NOP_CODE)) u_mux (
    .use_mem   (handoff),
    .mem_rdata (mem_rdata),
    .cpu_din   (cpu_din)
  );

  assign bus_en = handoff;
endmodule

// File: rtl/bvi_checks.sv
module bvi_checks #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              addr_valid,
  input logic              qual_hit,
  input logic              sync_hit,
  input logic              bus_en,
  input logic [DATA_W-1:0] cpu_din,
  input logic [DATA_W-1:0] mem_rdata
);
  logic rst_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q == 1'b1) begin
      a_r1_reset_clears: assert (!bus_en && cpu_din == '0);
    end
  end

  a_r2_nop_while_injecting: assert property (@(posedge clk) disable iff (rst)
    !bus_en |-> cpu_din == '0);

  a_r5_pass_through: assert property (@(posedge clk) disable iff (rst)
    bus_en |-> cpu_din == mem_rdata);

  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    bus_en |=> bus_en);

  a_r4_set_from_sync: assert property (@(posedge clk) disable iff (rst)
    sync_hit |=> bus_en);

  a_r3_rise_needs_sync: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_en) |-> $past(sync_hit));

  if (SYNC_STAGES == 1) begin : g_two_edge
    a_r4_two_edges: assert property (@(posedge clk) disable iff (rst)
      qual_hit |=> ##1 bus_en);
    a_r3_rise_needs_strobe: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_en) |-> $past(addr_valid, 2));
  end
endmodule

bind boot_vector_injector bvi_checks #(
  .DATA_W      (DATA_W),
  .SYNC_STAGES (SYNC_STAGES)
) u_checks (
  .clk        (clk),
  .rst        (rst),
  .addr_valid (addr_valid),
  .qual_hit   (qual_hit),
  .sync_hit   (sync_hit),
  .bus_en     (bus_en),
  .cpu_din    (cpu_din),
  .mem_rdata  (mem_rdata)
);

// File: tb/boot_vector_injector_bench.sv
module boot_vector_injector_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = 4'h0;
  logic       valid = 1'b0;
  logic [3:0] sel = 4'h0;
  logic [7:0] rdata = 8'h00;
  logic [7:0] cpu_din;
  logic       bus_en;

  int n_chk = 0;
  int n_bad = 0;
  int data_seed = 37;

  // Reference model: a queue standing for the delay line, plus a sticky flag.
  bit pend_q[$];
  bit m_done = 1'b0;

  always #10 clk = ~clk;

  boot_vector_injector u_boot_vector_injector (
    .clk (clk), .rst (rst), .cpu_addr_hi (addr), .addr_valid (valid),
    .jump_sel (sel), .mem_rdata (rdata), .cpu_din (cpu_din), .bus_en (bus_en)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic [3:0] a, input logic v,
                     input logic [3:0] s, input string tag);
    bit head;
    rst = r; addr = a; valid = v; sel = s;
    data_seed = (data_seed * 29 + 11) % 251;
    rdata = 8'(data_seed + 1);
    @(posedge clk);
    head = pend_q.pop_front();
    if (r) begin
      m_done = 1'b0;
      pend_q.push_back(1'b0);
    end else begin
      if (head) m_done = 1'b1;
      pend_q.push_back(v && (a == s));
    end
    @(negedge clk);
    chk({tag, " bus_en"}, {7'd0, bus_en}, {7'd0, m_done});
    chk({tag, " cpu_din"}, cpu_din, m_done ? rdata : 8'h00);
  endtask

  task automatic do_reset(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 4'h0, 1'b0, sel, "R1 reset");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    pend_q.push_back(1'b0);
    // R1: reset state
    do_reset(2);
    chk("R1 bus_en after reset", {7'd0, bus_en}, 8'h00);

    // R3: target nibble present but never strobed
    for (int i = 0; i < 6; i++) cyc(1'b0, 4'hB, 1'b0, 4'hB, "R3 unstrobed equal");
    chk("R3 still injecting", {7'd0, bus_en}, 8'h00);

    // Sweep with transient equal nibbles between strobes (R2, R4, R7)
    do_reset(1);
    for (int a = 0; a < 16; a++) begin
      cyc(1'b0, 4'hB, 1'b0, 4'hB, "R3 transient");
      cyc(1'b0, 4'(a), 1'b1, 4'hB, a < 11 ? "R2 inject" : "R5 R6 after");
      if (a == 11) begin
        chk("R4 one edge after match", {7'd0, bus_en}, 8'h00);
        cyc(1'b0, 4'hC, 1'b0, 4'hB, "R7 single pulse");
        chk("R4 two edges after match", {7'd0, bus_en}, 8'h01);
      end
    end

    // R6: later mismatches, strobes and switch changes do not undo hand-off
    for (int i = 0; i < 8; i++) cyc(1'b0, 4'(i), i[0], 4'(i + 3), "R6 sticky");
    chk("R5 pass-through", cpu_din, rdata);

    // R8: reset while the match sits in the synchronizing stage
    do_reset(1);
    cyc(1'b0, 4'h6, 1'b1, 4'h6, "R8 match");
    cyc(1'b1, 4'h0, 1'b0, 4'h6, "R8 reset");
    for (int i = 0; i < 4; i++) cyc(1'b0, 4'h1, 1'b1, 4'h6, "R8 idle");
    chk("R8 no hand-off", {7'd0, bus_en}, 8'h00);

    // R9: every switch value, near misses first
    for (int s = 0; s < 16; s++) begin
      do_reset(1);
      cyc(1'b0, 4'(s) ^ 4'h1, 1'b1, 4'(s), "R9 near miss");
      cyc(1'b0, 4'(s) ^ 4'h8, 1'b1, 4'(s), "R9 near miss");
      cyc(1'b0, 4'(s), 1'b1, 4'(s), "R9 match");
      cyc(1'b0, 4'(s) ^ 4'h4, 1'b1, 4'(s), "R9 wait");
      chk("R9 hand-off", {7'd0, bus_en}, 8'h01);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule